// File: doc/BRIEF.md
# Run-Mode System Clock Source Selector and Divider

This block holds a single 32-bit run-mode clock configuration word and drives the system clock path that the word describes. It receives a free-running oscillator clock and the output clock of a PLL. It produces one system clock. That clock is either the chosen source passed straight through, or the chosen source divided by a programmable integer from 2 to 16. The configuration word also supplies the PLL power-down control line.

The PLL path is taken only when three conditions hold together: the bypass bit is clear, the power-down bit is clear, and the PLL lock input (synchronised into the oscillator domain) is high. When the PLL path is taken, the divider is always used. Any requested divider code below a minimum is raised to that minimum, and the raised code is what a read returns. On the oscillator path, low codes are honoured as written. The divider counter loads a new divisor only when it wraps, so a reprogramming never produces a shortened pulse.

The configuration word is written whole through a write-enable and data bus, and read back through a combinational read bus. Bits that have no function are stored and returned unchanged, so a read-modify-write keeps them.

Top module: `run_clk_ctrl`

## Requirements
- R1: After reset, the read bus returns 0x07802800. This means divider code 0xF in bits 26:23, divider-use bit 22 at 0, power-down bit 13 at 1, and bypass bit 11 at 1. The `pll_pwrdn` output is 1.
- R2: On the oscillator path with bit 22 set, a divider code N from 1 to 15 gives a `sys_clk` period of (N+1) oscillator periods.
- R3: On the oscillator path with bit 22 clear, `sys_clk` is the oscillator clock itself.
- R4: When bypass is 0, power-down is 0 and lock is high, `sys_clk` is the PLL clock divided by (code+1), even while bit 22 is 0.
- R5: On the PLL path, a code below 7 divides by 8 and reads back as 7. A code of 7 or more reads back unchanged.
- R6: With bypass at 0 but power-down at 1 or lock low, the oscillator path is used, and a code below 7 is neither raised nor read back raised.
- R7: `pll_pwrdn` follows bit 13 of the stored word.
- R8: Every bit outside the divider field reads back exactly as last written.
- R9: Code 0 on the oscillator path with bit 22 set divides by 2 and reads back as 1.
- R10: A divided `sys_clk` stays high for floor(D/2) source periods of each D-period cycle. A new divisor is loaded only when the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; also clocks the configuration word |
| pll_clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| wr_en | input | 1 | Writes `wr_data` into the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Configuration word with the effective divider code |
| pll_pwrdn | output | 1 | PLL power-down control |
| sys_clk | output | 1 | System clock |

## Verification
The bench builds the block with its default parameters: a 4-bit divider field, a PLL minimum code of 7 and a two-stage lock synchroniser. With these values all sixteen divider codes can be reached in a short run, on both source paths. The bench gives the oscillator and the PLL different periods, so a measured period or high time shows which source fed the divider. Together with the readback, this separates the clamp, the forced divider use and the lock and power-down gating.

// File: rtl/rcc_cfg_pkg.sv
`timescale 1ns/1ps
package rcc_cfg_pkg;
   localparam int REG_W      = 32;
   localparam int DIV_W      = 4;
   localparam int DIV_LSB    = 23;
   localparam int USEDIV_BIT = 22;
   localparam int PWRDN_BIT  = 13;
   localparam int BYPASS_BIT = 11;
   localparam int PLL_MIN    = 7;
   localparam int DIV_RST    = 15;

   function automatic logic [REG_W-1:0] reset_word();
      logic [REG_W-1:0] w;
      w = '0;
      w[DIV_LSB +: DIV_W] = DIV_W'(DIV_RST);
      w[PWRDN_BIT]        = 1'b1;
      w[BYPASS_BIT]       = 1'b1;
      return w;
   endfunction
endpackage

// File: rtl/rcc_lock_sync.sv
`timescale 1ns/1ps
module rcc_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("rcc_lock_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else if (STAGES == 1) chain <= d;
         else chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/rcc_regs.sv
`timescale 1ns/1ps
module rcc_regs
   import rcc_cfg_pkg::*;
#(
   parameter int P_REG_W   = REG_W,
   parameter int P_DIV_W   = DIV_W,
   parameter int P_DIV_LSB = DIV_LSB,
   parameter int P_USE_BIT = USEDIV_BIT,
   parameter int P_PD_BIT  = PWRDN_BIT,
   parameter int P_BYP_BIT = BYPASS_BIT,
   parameter int P_MIN     = PLL_MIN
) (
   input  logic               osc_clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [P_REG_W-1:0] wr_data,
   input  logic               lock_s,
   output logic [P_REG_W-1:0] rd_data,
   output logic [P_DIV_W-1:0] div_code,
   output logic               use_div,
   output logic               pll_sel,
   output logic               pll_pwrdn
);
   localparam logic [P_DIV_W-1:0] MIN_V = P_DIV_W'(P_MIN);
   localparam logic [P_DIV_W-1:0] ONE_V = P_DIV_W'(1);

   if (P_DIV_LSB + P_DIV_W > P_REG_W) begin : g_bad_field
      $error("rcc_regs: divider field exceeds word");
   end
   if (P_MIN < 1 || P_MIN >= (1 << P_DIV_W)) begin : g_bad_min
      $error("rcc_regs: PLL minimum code out of range");
   end

   logic [P_REG_W-1:0] store;
   logic [P_DIV_W-1:0] raw_code, floor_code;
   logic               bypass_b, pwrdn_b, usediv_b;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n)     store <= P_REG_W'(reset_word());
      else if (wr_en) store <= wr_data;
   end

   assign raw_code = store[P_DIV_LSB +: P_DIV_W];
   assign bypass_b = store[P_BYP_BIT];
   assign pwrdn_b  = store[P_PD_BIT];
   assign usediv_b = store[P_USE_BIT];

   assign pll_sel    = !bypass_b && !pwrdn_b && lock_s;
   assign use_div    = pll_sel || usediv_b;
   assign pll_pwrdn  = pwrdn_b;
   assign floor_code = pll_sel ? MIN_V : ONE_V;
   assign div_code   = (raw_code < floor_code) ? floor_code : raw_code;

   always_comb begin
      rd_data = store;
      rd_data[P_DIV_LSB +: P_DIV_W] = div_code;
   end

   AST_WR_STORES: assert property (@(posedge osc_clk) disable iff (!rst_n)
      wr_en |=> store == $past(wr_data)); // R8
   AST_PLL_FLOOR: assert property (@(posedge osc_clk) disable iff (!rst_n)
      pll_sel |-> rd_data[P_DIV_LSB +: P_DIV_W] >= MIN_V); // R5
   AST_PWRDN_BLOCKS: assert property (@(posedge osc_clk) disable iff (!rst_n)
      pll_pwrdn |-> !pll_sel); // R6
   AST_NO_ZERO_CODE: assert property (@(posedge osc_clk) disable iff (!rst_n)
      rd_data[P_DIV_LSB +: P_DIV_W] != '0); // R9
endmodule

// File: rtl/rcc_div.sv
`timescale 1ns/1ps
module rcc_div #(
   parameter int DIV_W   = 4,
   parameter int RST_DIV = 16
) (
   input  logic           src_clk,
   input  logic           rst_n,
   input  logic [DIV_W:0] div_n,
   output logic           div_clk
);
   localparam int CNT_W = DIV_W + 1;

   if (RST_DIV < 2 || RST_DIV >= (1 << CNT_W)) begin : g_bad_rst
      $error("rcc_div: reset divisor out of range");
   end

   logic [CNT_W-1:0] cnt, div_q, half;
   logic             out_q, wrap;

   assign half = div_q >> 1;
   assign wrap = (cnt == div_q - CNT_W'(1));

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         div_q <= CNT_W'(RST_DIV);
         out_q <= 1'b1;
      end else if (wrap) begin
         cnt   <= '0;
         div_q <= div_n;
         out_q <= 1'b1;
      end else begin
         cnt   <= cnt + CNT_W'(1);
         out_q <= (cnt + CNT_W'(1)) < half;
      end
   end

   assign div_clk = out_q;

   AST_DIV_STEADY: assert property (@(posedge src_clk) disable iff (!rst_n)
      !wrap |=> $stable(div_q)); // R10
   AST_CNT_BOUND: assert property (@(posedge src_clk) disable iff (!rst_n)
      cnt < div_q); // R10
   AST_RISE_AT_WRAP: assert property (@(posedge src_clk) disable iff (!rst_n)
      $rose(out_q) |-> cnt == '0); // R10
   AST_DIV_LEGAL: assert property (@(posedge src_clk) disable iff (!rst_n)
      div_q >= CNT_W'(2)); // R2
endmodule

// File: rtl/run_clk_ctrl.sv
`timescale 1ns/1ps
module run_clk_ctrl
   import rcc_cfg_pkg::*;
#(
   parameter int LOCK_SYNC = 2,
   parameter int P_DIV_W   = DIV_W,
   parameter int P_MIN     = PLL_MIN
) (
   input  logic             osc_clk,
   input  logic             pll_clk,
   input  logic             rst_n,
   input  logic             pll_lock,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             pll_pwrdn,
   output logic             sys_clk
);
   localparam int RST_DIV = DIV_RST + 1;

   logic               lock_s, pll_sel, use_div, src_clk, div_clk;
   logic [P_DIV_W-1:0] div_code;
   logic [P_DIV_W:0]   div_n;

   rcc_lock_sync #(.STAGES(LOCK_SYNC)) u_lock (
      .clk(osc_clk), .rst_n(rst_n), .d(pll_lock), .q(lock_s));

   rcc_regs #(.P_DIV_W(P_DIV_W), .P_MIN(P_MIN)) u_regs (
      .osc_clk(osc_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .lock_s(lock_s), .rd_data(rd_data), .div_code(div_code),
      .use_div(use_div), .pll_sel(pll_sel), .pll_pwrdn(pll_pwrdn));

   assign src_clk = pll_sel ? pll_clk : osc_clk;
   assign div_n   = {1'b0, div_code} + (P_DIV_W+1)'(1);

   rcc_div #(.DIV_W(P_DIV_W), .RST_DIV(RST_DIV)) u_div (
      .src_clk(src_clk), .rst_n(rst_n), .div_n(div_n), .div_clk(div_clk));

   assign sys_clk = use_div ? div_clk : src_clk;

   AST_PLL_FORCES_DIV: assert property (@(posedge osc_clk) disable iff (!rst_n)
      pll_sel |-> sys_clk == div_clk); // R4
endmodule

// File: tb/run_clk_ctrl_bench.sv
`timescale 1ns/1ps
module run_clk_ctrl_bench;
   localparam real CLK_PERIOD = 10.0;
   localparam real PLL_PERIOD = 4.0;
   localparam logic [31:0] RSV = 32'h8000_4105;

   logic osc_clk = 0, pll_clk = 0, rst_n = 0, pll_lock = 0, wr_en = 0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic pll_pwrdn, sys_clk;

   int checks = 0, errors = 0;
   bit done_all = 0;
   real exp_per_q[$], exp_hi_q[$];
   string tag_q[$];
   event go_ev, done_ev;

   always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
   always #(PLL_PERIOD/2) pll_clk = ~pll_clk;

   run_clk_ctrl u_run_clk_ctrl (.osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n),
      .pll_lock(pll_lock), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .pll_pwrdn(pll_pwrdn), .sys_clk(sys_clk));

   function automatic logic [31:0] mk(int code, bit usediv, bit pwrdn, bit bypass);
      logic [31:0] w;
      w = RSV;
      w[26:23] = 4'(code);
      w[22] = usediv;
      w[13] = pwrdn;
      w[11] = bypass;
      return w;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic write_word(logic [31:0] w);
      @(negedge osc_clk);
      wr_en = 1; wr_data = w;
      @(negedge osc_clk);
      wr_en = 0;
      repeat (60) @(negedge osc_clk);
   endtask

   // driver side of the scoreboard: push expectation, start one measurement
   task automatic expect_clk(string tag, real per, real hi);
      exp_per_q.push_back(per);
      exp_hi_q.push_back(hi);
      tag_q.push_back(tag);
      ->go_ev;
      @(done_ev);
   endtask

   // monitor: measure one sys_clk cycle and compare with the queue head
   initial begin
      forever begin
         realtime t0, t1, t2;
         real ep, eh;
         string tg;
         @(go_ev);
         @(posedge sys_clk);
         @(posedge sys_clk); t0 = $realtime;
         @(negedge sys_clk); t1 = $realtime;
         @(posedge sys_clk); t2 = $realtime;
         ep = exp_per_q.pop_front();
         eh = exp_hi_q.pop_front();
         tg = tag_q.pop_front();
         checks++;
         if ((t2-t0) < ep-0.01 || (t2-t0) > ep+0.01) begin
            errors++;
            $display("FAIL %s period: actual %0.2f expected %0.2f", tg, t2-t0, ep);
         end
         checks++;
         if ((t1-t0) < eh-0.01 || (t1-t0) > eh+0.01) begin
            errors++;
            $display("FAIL %s high: actual %0.2f expected %0.2f", tg, t1-t0, eh);
         end
         ->done_ev;
      end
   end

   initial begin
      #(CLK_PERIOD*200000);
      if (!done_all) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge osc_clk);
      rst_n = 1;
      @(negedge osc_clk);
      chk("R1 reset word", rd_data, 32'h0780_2800);
      chk("R1 R7 reset pwrdn", {31'd0, pll_pwrdn}, 32'd1);
      expect_clk("R3 reset osc pass", CLK_PERIOD, CLK_PERIOD/2);

      for (int n = 1; n < 16; n++) begin
         write_word(mk(n, 1, 1, 1));
         chk("R2 R8 osc readback", rd_data, mk(n, 1, 1, 1));
         expect_clk("R2 R10 osc divide", (n+1)*CLK_PERIOD, ((n+1)/2)*CLK_PERIOD);
      end

      write_word(mk(0, 1, 1, 1));
      chk("R9 code0 readback", rd_data, mk(1, 1, 1, 1));
      expect_clk("R9 code0 divide", 2*CLK_PERIOD, CLK_PERIOD);

      pll_lock = 1;
      write_word(mk(3, 1, 1, 0));
      chk("R7 pwrdn high", {31'd0, pll_pwrdn}, 32'd1);
      chk("R6 pwrdn no clamp", rd_data, mk(3, 1, 1, 0));
      expect_clk("R6 pwrdn osc", 4*CLK_PERIOD, 2*CLK_PERIOD);

      pll_lock = 0;
      write_word(mk(3, 1, 0, 0));
      chk("R6 unlocked no clamp", rd_data, mk(3, 1, 0, 0));
      expect_clk("R6 unlocked osc", 4*CLK_PERIOD, 2*CLK_PERIOD);

      pll_lock = 1;
      for (int n = 0; n < 16; n++) begin
         int e;
         e = (n < 7) ? 7 : n;
         write_word(mk(n, 0, 0, 0));
         chk("R5 R8 pll readback", rd_data, mk(e, 0, 0, 0));
         expect_clk("R4 R5 pll divide", (e+1)*PLL_PERIOD, ((e+1)/2)*PLL_PERIOD);
      end
      chk("R7 pwrdn low", {31'd0, pll_pwrdn}, 32'd0);

      write_word(mk(2, 0, 0, 1));
      chk("R8 bypass readback", rd_data, mk(2, 0, 0, 1));
      expect_clk("R3 bypass pass", CLK_PERIOD, CLK_PERIOD/2);

      done_all = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule